// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block sets the timing of the serial clock for an I2C master. It works from a faster system clock and splits each SCL period into a low phase and a high phase. Each phase lasts a programmed divider, scaled by a power of two, plus two extra system clocks. The low-phase and high-phase dividers are separate fields. The power-of-two exponent is a single field shared by both phases. At the end of every phase the block gives the bit engine a one-cycle tick, and it always shows the SCL level it wants on the bus.

The configuration word is sampled only at a phase boundary, so a phase that is already running always completes with the settings it started with. A slave may hold SCL low (clock stretching). The high phase does not start counting until the sampled bus line reads high. A build parameter can clamp the exponent to a maximum value. With equal dividers D and exponent E, the SCL period is 2·D·2^E + 4 system clocks. A 100 kHz bus is the usual target and 400 kHz is the upper limit.

Top module: `scl_wavegen`

## Requirements
- R1: After reset, and from the cycle after `enable` is sampled low, `sclReq` is 1 (SCL released), `phaseTick` is 0 and the phase counter is zero. Dropping `enable` in the middle of a phase ends that phase at once.
- R2: When `enable` is sampled high while the block is idle, a low phase (`sclReq` = 0) begins in the next cycle.
- R3: The configuration word holds the low divider in bits [7:0], the high divider in bits [15:8] and the exponent in bits [18:16]. A low phase lasts lowDiv·2^exp + 2 cycles. A divider of zero gives a two-cycle phase.
- R4: A high phase lasts highDiv·2^exp + 2 cycles, counted from its first cycle in which `sclIn` is 1.
- R5: `phaseTick` is 1 for exactly one cycle, the last cycle of each phase, and `sclReq` toggles in the following cycle.
- R6: The configuration word is sampled only at the clock edge that starts a phase. Changes made during a phase do not alter that phase's length.
- R7: While a high phase has not yet started counting and `sclIn` is 0, the counter stays at zero and no tick is produced (clock stretching).
- R8: With `CAP_EN` = 1, an exponent above `EXP_MAX` (default 5) is treated as `EXP_MAX`. With `CAP_EN` = 0, every exponent value is used as programmed.
- R9: With equal dividers D and exponent E, and no stretching, the SCL period is 2·D·2^E + 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases SCL and clears the counter |
| cfgWord | input | 19 | Low divider [7:0], high divider [15:8], exponent [18:16] |
| sclIn | input | 1 | Sampled SCL bus level (already synchronised) |
| sclReq | output | 1 | Requested SCL level: 0 drive low, 1 release |
| phaseTick | output | 1 | One-cycle pulse in the last cycle of each phase |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One uses `CAP_EN` = 0 and the other uses `CAP_EN` = 1 with `EXP_MAX` = 5. Exponents 6 and 7 therefore produce phases of different lengths in the two copies, and both the clamped and the unclamped path are exercised in one run. The small default divider width keeps the phase lengths for zero dividers, ordinary dividers and large exponents short enough to run many complete periods. The bus line is modelled as the wired-AND of each copy's request with a bench-driven stretch signal, so stretching can be placed over the start of a high phase.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } wave_phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // counter to zero
    logic load;     // capture a new phase length
    logic selHigh;  // length comes from the high divider
    logic count;    // advance counter
  } wave_strb_t;

endpackage

// File: rtl/scl_wavegen_dp.sv
module scl_wavegen_dp
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int CNT_W   = 16,
  parameter bit CAP_EN  = 1'b0,
  parameter int EXP_MAX = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2*DIV_W+EXP_W-1:0]   cfgWord,
  input  wave_strb_t                 strb,
  output logic [CNT_W-1:0]           cntQ,
  output logic [CNT_W-1:0]           targetQ
);
  localparam int CFG_W = 2*DIV_W + EXP_W;

  logic [DIV_W-1:0] lowDiv, highDiv, selDiv;
  logic [EXP_W-1:0] rawExp, effExp;
  logic [CNT_W-1:0] nextTarget;

  assign lowDiv  = cfgWord[DIV_W-1:0];
  assign highDiv = cfgWord[2*DIV_W-1:DIV_W];
  assign rawExp  = cfgWord[CFG_W-1:2*DIV_W];

  generate
    if (CAP_EN) begin : g_cap
      assign effExp = (rawExp > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : rawExp;
    end else begin : g_nocap
      assign effExp = rawExp;
    end
  endgenerate

  assign selDiv     = strb.selHigh ? highDiv : lowDiv;
  assign nextTarget = (CNT_W'(selDiv) << effExp) + CNT_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      targetQ <= '0;
    end else begin
      if (strb.clear)      cntQ <= '0;
      else if (strb.count) cntQ <= cntQ + CNT_W'(1);
      if (strb.load)       targetQ <= nextTarget;
    end
  end

endmodule

// File: rtl/scl_wavegen_ctrl.sv
module scl_wavegen_ctrl
  import scl_wavegen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [CNT_W-1:0]  targetQ,
  output wave_phase_t       phaseQ,
  output wave_strb_t        strb,
  output logic              phaseTick
);
  wave_phase_t phaseD;
  logic lastCyc, cntZero, advance;

  assign lastCyc = (cntQ == targetQ - CNT_W'(1));
  assign cntZero = (cntQ == '0);

  always_comb begin
    phaseD    = phaseQ;
    strb      = '0;
    phaseTick = 1'b0;
    advance   = 1'b0;
    if (!enable) begin
      phaseD     = PH_OFF;
      strb.clear = 1'b1;
    end else begin
      unique case (phaseQ)
        PH_OFF: begin
          phaseD     = PH_LOW;
          strb.clear = 1'b1;
          strb.load  = 1'b1;
        end
        PH_LOW:  advance = 1'b1;
        PH_HIGH: advance = sclIn || !cntZero;  // wait for released line
        default: phaseD = PH_OFF;
      endcase
      if (advance) begin
        if (lastCyc) begin
          phaseTick    = 1'b1;
          strb.clear   = 1'b1;
          strb.load    = 1'b1;
          strb.selHigh = (phaseQ == PH_LOW);
          phaseD       = (phaseQ == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
          strb.count = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_OFF;
    else       phaseQ <= phaseD;
  end

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter bit CAP_EN  = 1'b0,
  parameter int EXP_MAX = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [2*DIV_W+EXP_W-1:0]  cfgWord,
  input  logic                      sclIn,
  output logic                      sclReq,
  output logic                      phaseTick
);
  // longest phase: (2^DIV_W-1)*2^(2^EXP_W-1)+2
  localparam int CNT_W = DIV_W + (1 << EXP_W);

  wave_phase_t      phaseQ;
  wave_strb_t       strb;
  logic [CNT_W-1:0] cntQ, targetQ;

  scl_wavegen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
    .cntQ(cntQ), .targetQ(targetQ),
    .phaseQ(phaseQ), .strb(strb), .phaseTick(phaseTick)
  );

  scl_wavegen_dp #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W),
    .CAP_EN(CAP_EN), .EXP_MAX(EXP_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .strb(strb),
    .cntQ(cntQ), .targetQ(targetQ)
  );

  assign sclReq = (phaseQ != PH_LOW);

endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 16,
  parameter bit CAP_EN  = 1'b0,
  parameter int EXP_MAX = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             sclIn,
  input logic             sclReq,
  input logic             phaseTick,
  input wave_phase_t      phase,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] targetQ
);
  localparam int CAP_LEN = ((1 << DIV_W) - 1) * (1 << EXP_MAX) + 2;

  p_release_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclReq && cntQ == '0));

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OFF && enable) |=> !sclReq);

  p_low_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sclReq && !phaseTick) |=> !sclReq);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_OFF) |-> (cntQ < targetQ));

  p_tick_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    phaseTick |=> !phaseTick);

  p_tick_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phaseTick && enable) |=> (sclReq != $past(sclReq)));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_OFF && enable && !phaseTick) |=> $stable(targetQ));

  p_stretch_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && enable && !sclIn && cntQ == '0) |=> (cntQ == '0));

  generate
    if (CAP_EN) begin : g_capchk
      p_cap_len_r8: assert property (@(posedge clk) disable iff (!rstN)
        int'(targetQ) <= CAP_LEN);
    end
  endgenerate

endmodule

bind scl_wavegen scl_wavegen_chk #(
  .DIV_W(DIV_W), .CNT_W(CNT_W), .CAP_EN(CAP_EN), .EXP_MAX(EXP_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
  .sclReq(sclReq), .phaseTick(phaseTick), .phase(phaseQ),
  .cntQ(cntQ), .targetQ(targetQ)
);

// File: tb/tb_scl_wavegen.sv
`timescale 1ns/1ps
module tb_scl_wavegen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [18:0] cfgWord = '0;
  logic        hold = 1'b0;
  logic        reqV [2];
  logic        tickV [2];
  logic        sclInV [2];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  string       curReq = "R1";

  always #10 clk = ~clk;

  // bus line: wired-AND of the request and a stretching slave
  assign sclInV[0] = reqV[0] & ~hold;
  assign sclInV[1] = reqV[1] & ~hold;

  scl_wavegen #(.CAP_EN(1'b0)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .sclIn(sclInV[0]), .sclReq(reqV[0]), .phaseTick(tickV[0]));

  scl_wavegen #(.CAP_EN(1'b1), .EXP_MAX(5)) dutCap (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .sclIn(sclInV[1]), .sclReq(reqV[1]), .phaseTick(tickV[1]));

  // reference model: 0 idle, 1 low, 2 high
  int mPh [2];
  int mCnt [2];
  int mLen [2];

  function automatic int lenOf(int d, int e, bit cap);
    int ee = e;
    if (cap && ee > 5) ee = 5;
    return d * (1 << ee) + 2;
  endfunction

  function automatic bit modelBus(int k);
    return (mPh[k] != 1) && !hold;
  endfunction

  function automatic bit modelAdv(int k);
    return (mPh[k] == 1) || (mPh[k] == 2 && (modelBus(k) || mCnt[k] != 0));
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rstN || !enable) begin
        mPh[k] = 0; mCnt[k] = 0;
      end else if (mPh[k] == 0) begin
        mPh[k] = 1; mCnt[k] = 0;
        mLen[k] = lenOf(int'(cfgWord[7:0]), int'(cfgWord[18:16]), k == 1);
      end else if (modelAdv(k)) begin
        if (mCnt[k] == mLen[k] - 1) begin
          mCnt[k] = 0;
          if (mPh[k] == 1) begin
            mPh[k] = 2;
            mLen[k] = lenOf(int'(cfgWord[15:8]), int'(cfgWord[18:16]), k == 1);
          end else begin
            mPh[k] = 1;
            mLen[k] = lenOf(int'(cfgWord[7:0]), int'(cfgWord[18:16]), k == 1);
          end
        end else begin
          mCnt[k] = mCnt[k] + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    #5;
    for (int k = 0; k < 2; k++) begin
      bit expReq, expTick;
      expReq  = (mPh[k] != 1);
      expTick = enable && mPh[k] != 0 && modelAdv(k) && (mCnt[k] == mLen[k] - 1);
      checks++;
      if (reqV[k] !== expReq) begin
        fails++;
        $display("FAIL %s dut%0d sclReq got %0b exp %0b at %0t", curReq, k, reqV[k], expReq, $time);
      end
      checks++;
      if (tickV[k] !== expTick) begin
        fails++;
        $display("FAIL %s dut%0d phaseTick got %0b exp %0b at %0t", curReq, k, tickV[k], expTick, $time);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  // SCL period: rising edge to rising edge of the request
  task automatic measurePeriod(int k, output int n);
    logic prv;
    prv = reqV[k];
    forever begin @(negedge clk); if (!prv && reqV[k]) break; prv = reqV[k]; end
    n = 0; prv = reqV[k];
    forever begin @(negedge clk); n++; if (!prv && reqV[k]) break; prv = reqV[k]; end
  endtask

  task automatic measureLow(int k, output int n);
    logic prv;
    prv = reqV[k];
    forever begin @(negedge clk); if (prv && !reqV[k]) break; prv = reqV[k]; end
    n = 0;
    while (!reqV[k]) begin n++; @(negedge clk); end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int n;
    cycles(3);
    // R1: reset state
    checkVal("R1", "reset sclReq", int'(reqV[0]), 1);
    checkVal("R1", "reset phaseTick", int'(tickV[0]), 0);
    rstN = 1'b1;
    cycles(3);
    // R2, R3: low 2*1+2=4, high 3*1+2=5
    curReq = "R2";
    cfgWord = {3'd0, 8'd3, 8'd2};
    enable = 1'b1;
    cycles(4);
    curReq = "R3";
    cycles(40);
    // R4, R5: exp 2 -> low 6, high 10
    curReq = "R4";
    cfgWord = {3'd2, 8'd2, 8'd1};
    cycles(60);
    curReq = "R5";
    cycles(30);
    // R6: change configuration mid-phase several times
    curReq = "R6";
    cfgWord = {3'd1, 8'd4, 8'd3};
    cycles(7);
    cfgWord = {3'd0, 8'd1, 8'd5};
    cycles(3);
    cfgWord = {3'd1, 8'd0, 8'd2};
    cycles(40);
    // R3 boundary: zero dividers with largest exponent give 2-cycle phases
    curReq = "R3";
    cfgWord = {3'd7, 8'd0, 8'd0};
    cycles(20);
    // R7: stretch over the start of high phases
    curReq = "R7";
    cfgWord = {3'd0, 8'd4, 8'd3};
    cycles(5);
    hold = 1'b1;
    cycles(23);
    hold = 1'b0;
    cycles(30);
    hold = 1'b1;
    cycles(4);
    hold = 1'b0;
    cycles(20);
    // R1: disable mid-phase, then R2 restart
    curReq = "R1";
    enable = 1'b0;
    cycles(1);
    checkVal("R1", "disabled sclReq", int'(reqV[0]), 1);
    cycles(5);
    curReq = "R2";
    enable = 1'b1;
    cycles(30);
    // R8: exp 6 -> 66 uncapped, 34 capped
    curReq = "R8";
    cfgWord = {3'd6, 8'd1, 8'd1};
    measureLow(1, n);
    checkVal("R8", "capped low length", n, 34);
    measureLow(0, n);
    checkVal("R8", "uncapped low length", n, 66);
    cfgWord = {3'd7, 8'd1, 8'd2};
    cycles(300);
    // R9: period formula
    cfgWord = {3'd1, 8'd3, 8'd3};
    cycles(80);
    curReq = "R9";
    measurePeriod(0, n);
    checkVal("R9", "period exp1 div3", n, 2 * 3 * 2 + 4);
    cfgWord = {3'd3, 8'd5, 8'd5};
    measurePeriod(0, n);
    measurePeriod(0, n);
    checkVal("R9", "period exp3 div5", n, 2 * 5 * 8 + 4);
    cycles(5);
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

endmodule